// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static Memory Controller

This block connects a synchronous request port inside the chip to an external asynchronous static memory of 512K words by 32 bits. The memory is split into four 8-bit byte lanes, each enabled by its own active-low select. The lanes share one active-low write strobe and one active-low output enable. The data bus is brought out as three separate signals: an output value, an output enable and a sampled input. Every phase of a memory access lasts a whole number of clock cycles. These counts come from nanosecond parameters, rounded up to the clock period, so one controller can be retargeted to any clock rate or memory speed grade by changing its parameters alone.

Requests use a valid/ready handshake. The requester raises `req_valid` with the operation fields and holds them until it sees `req_ready` high at a clock edge. The fields may change freely after that edge. `req_ready` is high only while the controller is idle, so each transaction is a single beat. A write carries a 4-bit lane mask. Only the lanes whose mask bit is set have their selects asserted, so bytes outside the mask are left unchanged in memory. A read enables all four lanes and returns the 32-bit word on `rd_data`, with a one-cycle `rd_valid` pulse. The read result has no ready: the consumer must take it in the cycle it appears. `rd_data` keeps that value until the next read completes.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, and whenever no transaction is in progress, every lane select, the write strobe and the output enable are high (1111, 1, 1), the data output enable is 0, `req_ready` is 1 and `rd_valid` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the transaction ends, and at least one fully deasserted idle cycle separates any two transactions.
- R3: With N(t) = max(1, ceil(t / CLK_NS)), a write holds the strobe high for N(T_AS) cycles after acceptance, then low for N(T_WP) cycles, then high again for N(T_AH) hold cycles before going idle.
- R4: During all three write phases, lane select i is the inverse of mask bit i. Lane i carries data bits 8i+7..8i, so bit 0 selects bits 7..0 and bit 3 selects bits 31..24. A mask of 0000 runs the full strobe sequence with every select high.
- R5: During a write, the data output enable is 1 and `mem_dq_out` equals the accepted write data exactly while the strobe is low. The output enable stays high for the whole write.
- R6: `mem_addr` equals the accepted address from the first cycle after acceptance until the transaction ends, so it covers both the setup and the hold phase.
- R7: A read drives all four selects low and the output enable low, with the strobe high, for N_RD = max(N(T_AA), N(T_RC)) cycles, then goes idle.
- R8: `mem_dq_in` is captured at the clock edge that ends the last read cycle. `rd_valid` is 1 for exactly the next cycle, with `rd_data` equal to the captured word, and `rd_data` holds that word until the next read completes.
- R9: While `req_ready` is 0, changes on `req_valid`, `req_write`, `req_addr`, `req_wdata` and `req_mask` have no effect on the memory pins or on the data stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Write lane mask, bit i = lane i |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | 32 | Last read word |
| mem_addr | output | 19 | Memory address pins |
| mem_cs_n | output | 4 | Active-low lane selects |
| mem_we_n | output | 1 | Active-low shared write strobe |
| mem_oe_n | output | 1 | Active-low shared output enable |
| mem_dq_out | output | 32 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 32 | Data sampled from memory pins |

## Verification
The assertions assume only a clean reset and a requester that obeys the handshake. They state pin relations that must hold whatever arrives on `mem_dq_in` or the request fields: no overlap of strobe and output enable, data driven only under a low strobe, fully deasserted pins whenever ready, a stable address within a transaction, and selects held as the strobe rises. The stimulus keeps `req_valid` and its fields steady until acceptance. It then deliberately scrambles the fields while the controller is busy, so that any leak of those inputs into the pins shows up. A memory model in the bench stores the bytes written through the selects and strobe. The read-back values are then checked against a separate lane-masked shadow kept from the requests alone.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W_SETUP,
    ST_W_PULSE,
    ST_W_HOLD,
    ST_R_ACCESS
  } seq_state_t;

  // Cycles needed to cover a time, rounded up, never less than one.
  function automatic int unsigned ns_to_cyc(int unsigned t_ns, int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 2,
  parameter int unsigned N_AS   = 1,
  parameter int unsigned N_WP   = 1,
  parameter int unsigned N_AH   = 1,
  parameter int unsigned N_RD   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic              t_last,
  output logic              t_load,
  output logic [CNT_W-1:0]  t_val,
  output logic              cap_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  localparam logic [CNT_W-1:0] V_AS = CNT_W'(N_AS - 1);
  localparam logic [CNT_W-1:0] V_WP = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] V_AH = CNT_W'(N_AH - 1);
  localparam logic [CNT_W-1:0] V_RD = CNT_W'(N_RD - 1);

  seq_state_t        st_q, st_d;
  logic              accept;
  logic [LANES-1:0]  mask_q, mask_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_n_q, oe_n_q, dq_oe_q;
  logic              wr_phase_d, rd_phase_d;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mask_d    = accept ? req_mask : mask_q;

  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = '0;
    cap_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          t_load = 1'b1;
          if (req_write) begin
            st_d  = ST_W_SETUP;
            t_val = V_AS;
          end else begin
            st_d  = ST_R_ACCESS;
            t_val = V_RD;
          end
        end
      end
      ST_W_SETUP: begin
        if (t_last) begin
          st_d   = ST_W_PULSE;
          t_load = 1'b1;
          t_val  = V_WP;
        end
      end
      ST_W_PULSE: begin
        if (t_last) begin
          st_d   = ST_W_HOLD;
          t_load = 1'b1;
          t_val  = V_AH;
        end
      end
      ST_W_HOLD: begin
        if (t_last) st_d = ST_IDLE;
      end
      ST_R_ACCESS: begin
        if (t_last) begin
          st_d   = ST_IDLE;
          cap_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign wr_phase_d = (st_d == ST_W_SETUP) || (st_d == ST_W_PULSE) || (st_d == ST_W_HOLD);
  assign rd_phase_d = (st_d == ST_R_ACCESS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      mask_q  <= mask_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      we_n_q  <= (st_d != ST_W_PULSE);
      oe_n_q  <= !rd_phase_d;
      dq_oe_q <= (st_d == ST_W_PULSE);
    end
  end

  // One registered select per lane: masked during a write, all on for a read.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic cs_n_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cs_n_q <= 1'b1;
      end else begin
        cs_n_q <= !((wr_phase_d && mask_d[g]) || rd_phase_d);
      end
    end
    assign mem_cs_n[g] = cs_n_q;
  end

  assign mem_addr   = addr_q;
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = dq_oe_q;

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= dq_in;
    end
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned T_AS   = 2,
  parameter int unsigned T_WP   = 15,
  parameter int unsigned T_AH   = 1,
  parameter int unsigned T_RC   = 17,
  parameter int unsigned T_AA   = 17,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned N_AS  = ns_to_cyc(T_AS, CLK_NS);
  localparam int unsigned N_WP  = ns_to_cyc(T_WP, CLK_NS);
  localparam int unsigned N_AH  = ns_to_cyc(T_AH, CLK_NS);
  localparam int unsigned N_RD  = max2(ns_to_cyc(T_AA, CLK_NS), ns_to_cyc(T_RC, CLK_NS));
  localparam int unsigned N_MAX = max2(max2(N_AS, N_WP), max2(N_AH, N_RD));
  localparam int unsigned CNT_W = $clog2(N_MAX + 1);

  logic             t_load, t_last, cap_en;
  logic [CNT_W-1:0] t_val;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  sram_lane_seq #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .N_AS   (N_AS),
    .N_WP   (N_WP),
    .N_AH   (N_AH),
    .N_RD   (N_RD)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .t_last     (t_last),
    .t_load     (t_load),
    .t_val      (t_val),
    .cap_en     (cap_en),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  sram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .dq_in    (mem_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_cs_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);

  a_r2_ready_means_parked: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&mem_cs_n) && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r3_select_kept_at_strobe_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_cs_n == $past(mem_cs_n)));

  a_r5_drive_only_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n && mem_oe_n));

  a_r6_addr_steady_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  a_r7_no_read_write_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rd_valid  (rd_valid),
  .mem_addr  (mem_addr),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_lane_ctrl.sv
`timescale 1ns/1ps
module sim_sram_lane_ctrl;

  // 20 ns clock; N(t)=ceil(t/20): T_AS=25->2, T_WP=45->3, T_AH=21->2, T_AA=55->3, T_RC=17->1
  localparam int NAS = 2;
  localparam int NWP = 3;
  localparam int NAH = 2;
  localparam int NRD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_mask = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [18:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_we_n, mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_out;
  logic [31:0] mem_dq_in;

  always #10 clk = ~clk;

  sram_lane_ctrl #(
    .CLK_NS(20), .T_AS(25), .T_WP(45), .T_AH(21), .T_RC(17), .T_AA(55)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit scrambled = 0;

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] init_word(int a);
    return (32'(a) * 32'h0001_0003) ^ 32'h5A5A_C3C3;
  endfunction

  // ---------------- memory model driven only by the pins ----------------
  logic [31:0] mem_store [int];
  logic        wr_pend = 0;
  logic [18:0] wr_a;
  logic [3:0]  wr_cs;
  logic [31:0] wr_d;

  function automatic logic [31:0] mem_get(int a);
    return mem_store.exists(a) ? mem_store[a] : init_word(a);
  endfunction

  always_comb begin
    mem_dq_in = 32'h0;
    if (!mem_oe_n && mem_we_n) begin
      for (int i = 0; i < 4; i++)
        if (!mem_cs_n[i]) mem_dq_in[8*i +: 8] = mem_get(int'(mem_addr))[8*i +: 8];
    end
  end

  always @(negedge clk) begin
    if (!mem_we_n) begin
      wr_pend <= 1;
      wr_a  <= mem_addr;
      wr_cs <= mem_cs_n;
      wr_d  <= mem_dq_oe ? mem_dq_out : 32'hBAD0_BAD0;
    end else if (wr_pend) begin
      logic [31:0] w;
      w = mem_get(int'(wr_a));
      for (int i = 0; i < 4; i++)
        if (!wr_cs[i]) w[8*i +: 8] = wr_d[8*i +: 8];
      mem_store[int'(wr_a)] = w;
      wr_pend <= 0;
    end
  end

  // ---------------- reference model: per-cycle expected pin schedule ----------------
  typedef struct packed {
    logic        rdy;
    logic [3:0]  cs_n;
    logic        we_n;
    logic        oe_n;
    logic        dq_oe;
    logic [31:0] dq;
    logic        achk;
    logic [18:0] addr;
    logic        rv;
    logic [31:0] rdat;
  } exp_t;

  localparam exp_t IDLE_E = '{rdy:1'b1, cs_n:4'hF, we_n:1'b1, oe_n:1'b1, dq_oe:1'b0,
                              dq:32'h0, achk:1'b0, addr:19'h0, rv:1'b0, rdat:32'h0};

  exp_t        sched[$];
  exp_t        cur = IDLE_E;
  logic [31:0] exp_rdata = 32'h0;
  logic [31:0] shadow [int];

  function automatic logic [31:0] shadow_get(int a);
    return shadow.exists(a) ? shadow[a] : init_word(a);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      sched.delete();
      cur = IDLE_E;
      exp_rdata = 32'h0;
    end else begin
      if (cur.rdy && req_valid) begin
        exp_t e;
        e = IDLE_E;
        e.rdy = 1'b0;
        e.achk = 1'b1;
        e.addr = req_addr;
        if (req_write) begin
          logic [31:0] w;
          e.cs_n = ~req_mask;
          for (int i = 0; i < NAS; i++) sched.push_back(e);
          e.we_n = 1'b0; e.dq_oe = 1'b1; e.dq = req_wdata;
          for (int i = 0; i < NWP; i++) sched.push_back(e);
          e.we_n = 1'b1; e.dq_oe = 1'b0; e.dq = 32'h0;
          for (int i = 0; i < NAH; i++) sched.push_back(e);
          w = shadow_get(int'(req_addr));
          for (int i = 0; i < 4; i++)
            if (req_mask[i]) w[8*i +: 8] = req_wdata[8*i +: 8];
          shadow[int'(req_addr)] = w;
        end else begin
          exp_t f;
          e.cs_n = 4'h0; e.oe_n = 1'b0;
          for (int i = 0; i < NRD; i++) sched.push_back(e);
          f = IDLE_E;
          f.rv = 1'b1;
          f.rdat = shadow_get(int'(req_addr));
          sched.push_back(f);
        end
      end
      if (sched.size() > 0) cur = sched.pop_front();
      else cur = IDLE_E;
      if (cur.rv) exp_rdata = cur.rdat;
    end
  end

  // ---------------- per-cycle comparison away from the active edge ----------------
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(mem_cs_n == 4'hF && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", "pins in reset",
          {25'h0, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, {25'h0, 4'hF, 3'b110});
      chk(req_ready && !rd_valid, "R1", "ready/valid in reset",
          {30'h0, req_ready, rd_valid}, 32'h2);
    end else begin
      string t_sel;
      t_sel = scrambled ? "R9" : (cur.rdy ? "R1" : (cur.oe_n ? "R4" : "R7"));
      chk(req_ready == cur.rdy, "R2", "req_ready", 32'(req_ready), 32'(cur.rdy));
      chk(mem_cs_n == cur.cs_n, t_sel, "mem_cs_n", 32'(mem_cs_n), 32'(cur.cs_n));
      chk(mem_we_n == cur.we_n, "R3", "mem_we_n", 32'(mem_we_n), 32'(cur.we_n));
      chk(mem_oe_n == cur.oe_n, (cur.oe_n ? "R5" : "R7"), "mem_oe_n", 32'(mem_oe_n), 32'(cur.oe_n));
      chk(mem_dq_oe == cur.dq_oe, "R5", "mem_dq_oe", 32'(mem_dq_oe), 32'(cur.dq_oe));
      if (cur.dq_oe)
        chk(mem_dq_out == cur.dq, scrambled ? "R9" : "R5", "mem_dq_out", mem_dq_out, cur.dq);
      if (cur.achk)
        chk(mem_addr == cur.addr, scrambled ? "R9" : "R6", "mem_addr", 32'(mem_addr), 32'(cur.addr));
      chk(rd_valid == cur.rv, "R8", "rd_valid", 32'(rd_valid), 32'(cur.rv));
      chk(rd_data == exp_rdata, "R8", "rd_data", rd_data, exp_rdata);
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      n_checks++;
      $display("FAIL R2 watchdog: cycles=%0d expected below %0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(bit w, logic [18:0] a, logic [31:0] d, logic [3:0] m);
    bit r;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    forever begin
      @(negedge clk);
      r = req_ready;
      @(posedge clk);
      #1;
      if (r) break;
    end
    // R9: scramble every request field while the controller is busy
    req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~d; req_mask = ~m;
    scrambled = 1'b1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    scrambled = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;

    // R7/R8: read of a never-written word returns the memory content
    issue(0, 19'h00010, 32'h0, 4'h0);
    wait_idle();
    // R3/R4/R5: full-width write then read back
    issue(1, 19'h00010, 32'h1122_3344, 4'hF);
    wait_idle();
    issue(0, 19'h00010, 32'h0, 4'h0);
    wait_idle();
    // R4: single-lane and alternate-lane writes
    issue(1, 19'h00010, 32'hAAAA_AAAA, 4'b0001);
    wait_idle();
    issue(1, 19'h00010, 32'h5555_5555, 4'b1010);
    wait_idle();
    // R4: empty mask leaves stored data intact
    issue(1, 19'h00010, 32'hFFFF_FFFF, 4'b0000);
    wait_idle();
    issue(0, 19'h00010, 32'h0, 4'h0);
    wait_idle();
    // R6: address boundaries
    issue(1, 19'h7FFFF, 32'hDEAD_BEEF, 4'b1100);
    wait_idle();
    issue(1, 19'h00000, 32'hCAFE_F00D, 4'b0110);
    wait_idle();
    // R2/R8: back-to-back reads, then write followed directly by a read
    issue(0, 19'h7FFFF, 32'h0, 4'h0);
    issue(0, 19'h00000, 32'h0, 4'h0);
    issue(1, 19'h00123, 32'h0BAD_F00D, 4'hF);
    issue(0, 19'h00123, 32'h0, 4'h0);
    wait_idle();
    repeat (8) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule